// File: doc/BRIEF.md
# Bus-Shared Universal Shift Register

This block is a parameterized register (eight bits by default) whose parallel data lines are one shared, bidirectional bus. A two-bit function select picks one of four operations on each rising clock edge. The register can keep its value, move its contents one place toward the high end, move them one place toward the low end, or take a new word from the bus. Two active-low output controls gate the bus drivers. An active-low asynchronous clear empties the register at once.

Each tri-state bus pin appears at the boundary as three plain signals: a data input, a data output and a single enable for the whole bus. An enclosing pad or bus model builds the real tri-state from these. When load is selected, the enable is forced low so that an outside agent can drive the lines and have its word captured.

Two serial inputs feed the ends of the register during shifts. Two serial outputs always show the lowest and highest bits. Chaining the high serial output of one stage into the low serial input of the next, and the reverse, builds words of any multiple of the width.

The four operating modes act as the block's states. They are HOLD (select 00), SHIFT_UP (01), SHIFT_DOWN (10) and LOAD (11). Any mode may follow any other on the next edge; the select alone names the transition. CLEAR is an asynchronous override that leaves every mode.

Top module: `usr_bus_shreg`

## Requirements
- R1: With select `{sel[1],sel[0]}` = 00 (hold), the register value after a rising edge equals its value before it.
- R2: With select 01 (shift up), each bit i moves to bit i+1 on the rising edge, and bit 0 takes `ser_up_in`.
- R3: With select 10 (shift down), each bit i+1 moves to bit i on the rising edge, and the top bit takes `ser_dn_in`.
- R4: With select 11 (load), the register captures `bus_in` on the rising edge.
- R5: `bus_oe` is 1 only when both `oc_n` bits are 0 and the select is not 11; select 11 forces `bus_oe` to 0 whatever `oc_n` holds.
- R6: While `clr_n` is 0, every register bit is 0 at once, without waiting for a clock edge, whatever the select, `oc_n` or `bus_in`.
- R7: `ser_lo_out` always equals register bit 0 and `ser_hi_out` always equals the top register bit, independent of `oc_n`.
- R8: Two instances chained through their serial pins (low stage `ser_hi_out` to high stage `ser_up_in`, high stage `ser_lo_out` to low stage `ser_dn_in`) shift and hold as one word of twice the width.
- R9: `bus_out` presents the register contents in every mode, so the value can be read whenever `bus_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Function select: 00 hold, 01 shift up, 10 shift down, 11 load |
| oc_n | input | 2 | Output controls, active low; both must be 0 to drive |
| ser_up_in | input | 1 | Serial input entering bit 0 during shift up |
| ser_dn_in | input | 1 | Serial input entering the top bit during shift down |
| bus_in | input | WIDTH | Data seen on the shared bus lines |
| bus_out | output | WIDTH | Register contents offered to the bus drivers |
| bus_oe | output | 1 | Bus driver enable for all lines |
| ser_lo_out | output | 1 | Register bit 0, always driven |
| ser_hi_out | output | 1 | Top register bit, always driven |

## Verification
The hardest case to reach from the ports is a clear that lands between clock edges while a shift is under way. The outputs must drop to zero at once, not on the next edge, and must stay zero across an edge that would otherwise load a non-zero bus word. The bench drops `clr_n` one nanosecond after a shifting edge and samples the outputs half a nanosecond later. It keeps the clear low through an edge with load selected and all-ones on the bus. Two chained instances run against a double-width behavioural model, so serial hand-off errors between stages show up in the high word.

// File: rtl/usr_pkg.sv
`timescale 1ns/1ps
package usr_pkg;

    // Operating modes, encoded as {S1,S0} on the select pins
    typedef enum logic [1:0] {
        MODE_HOLD       = 2'b00,
        MODE_SHIFT_UP   = 2'b01,
        MODE_SHIFT_DOWN = 2'b10,
        MODE_LOAD       = 2'b11
    } mode_e;

    localparam int OC_LINES = 2;

endpackage

// File: rtl/usr_mode_decode.sv
`timescale 1ns/1ps
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0]          sel,
    input  logic [OC_LINES-1:0] oc_n,
    output mode_e               mode,
    output logic                drive_en
);

    logic oc_all_low;

    assign oc_all_low = ~|oc_n;

    // Mode register input: the select names the next operation directly
    always_comb begin
        mode = MODE_HOLD;
        unique case (sel)
            2'b00: mode = MODE_HOLD;
            2'b01: mode = MODE_SHIFT_UP;
            2'b10: mode = MODE_SHIFT_DOWN;
            2'b11: mode = MODE_LOAD;
        endcase
    end

    // Drivers release the bus during load so outside data can be captured
    always_comb begin
        drive_en = 1'b0;
        unique case (mode)
            MODE_HOLD,
            MODE_SHIFT_UP,
            MODE_SHIFT_DOWN: drive_en = oc_all_low;
            MODE_LOAD:       drive_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/usr_bit_slice.sv
`timescale 1ns/1ps
module usr_bit_slice
    import usr_pkg::*;
(
    input  mode_e mode,
    input  logic  cur_bit,
    input  logic  from_lower,
    input  logic  from_upper,
    input  logic  par_bit,
    output logic  nxt_bit
);

    always_comb begin
        nxt_bit = cur_bit;
        unique case (mode)
            MODE_HOLD:       nxt_bit = cur_bit;
            MODE_SHIFT_UP:   nxt_bit = from_lower;
            MODE_SHIFT_DOWN: nxt_bit = from_upper;
            MODE_LOAD:       nxt_bit = par_bit;
        endcase
    end

endmodule

// File: rtl/usr_bus_shreg.sv
`timescale 1ns/1ps
module usr_bus_shreg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                clk,
    input  logic                clr_n,
    input  logic [1:0]          sel,
    input  logic [OC_LINES-1:0] oc_n,
    input  logic                ser_up_in,
    input  logic                ser_dn_in,
    input  logic [WIDTH-1:0]    bus_in,
    output logic [WIDTH-1:0]    bus_out,
    output logic                bus_oe,
    output logic                ser_lo_out,
    output logic                ser_hi_out
);

    localparam int TOP = WIDTH - 1;

    mode_e            mode;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] q_nxt;

    usr_mode_decode u_decode (
        .sel      (sel),
        .oc_n     (oc_n),
        .mode     (mode),
        .drive_en (bus_oe)
    );

    // One next-value slice per bit; the end slices take the serial inputs
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic lower_src;
        logic upper_src;

        if (i == 0) begin : g_lo_end
            assign lower_src = ser_up_in;
        end else begin : g_lo_mid
            assign lower_src = q[i-1];
        end

        if (i == TOP) begin : g_hi_end
            assign upper_src = ser_dn_in;
        end else begin : g_hi_mid
            assign upper_src = q[i+1];
        end

        usr_bit_slice u_slice (
            .mode       (mode),
            .cur_bit    (q[i]),
            .from_lower (lower_src),
            .from_upper (upper_src),
            .par_bit    (bus_in[i]),
            .nxt_bit    (q_nxt[i])
        );
    end

    // State register with asynchronous clear
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

    assign bus_out    = q;
    assign ser_lo_out = q[0];
    assign ser_hi_out = q[TOP];

endmodule

// File: rtl/usr_bus_shreg_checker.sv
`timescale 1ns/1ps
module usr_bus_shreg_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       sel,
    input logic [1:0]       oc_n,
    input logic             ser_up_in,
    input logic             ser_dn_in,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic             ser_lo_out,
    input logic             ser_hi_out
);

    assert_hold_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b00) |=> (bus_out == $past(bus_out)));

    assert_shift_up_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b01) |=> (bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_up_in)}));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b10) |=> (bus_out == {$past(ser_dn_in), $past(bus_out[WIDTH-1:1])}));

    assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b11) |=> (bus_out == $past(bus_in)));

    assert_load_releases_bus_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b11) |-> !bus_oe);

    assert_oc_gates_bus_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (oc_n != 2'b00) |-> !bus_oe);

    assert_drive_when_enabled_R5: assert property (@(posedge clk) disable iff (!clr_n)
        ((oc_n == 2'b00) && (sel != 2'b11)) |-> bus_oe);

    assert_clear_zero_R6: assert property (@(posedge clk)
        !clr_n |-> (bus_out == '0));

    assert_serial_ends_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (ser_lo_out == bus_out[0]) && (ser_hi_out == bus_out[WIDTH-1]));

endmodule

bind usr_bus_shreg usr_bus_shreg_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/usr_bus_shreg_bench.sv
`timescale 1ns/1ps
module usr_bus_shreg_bench;

    localparam int W  = 8;
    localparam int W2 = 2 * W;

    logic          clk = 1'b0;
    logic          clr_n;
    logic [1:0]    sel;
    logic [1:0]    oc_n;
    logic          dsr;
    logic          dsl;
    logic [W2-1:0] bin;

    logic [W-1:0]  lo_out, hi_out;
    logic          lo_oe, hi_oe;
    logic          lo_ser_lo, lo_ser_hi, hi_ser_lo, hi_ser_hi;

    int checks   = 0;
    int failures = 0;
    logic [W2-1:0] model;

    always #2 clk = ~clk;

    usr_bus_shreg #(.WIDTH(W)) u_usr_bus_shreg (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oc_n(oc_n),
        .ser_up_in(dsr), .ser_dn_in(hi_ser_lo), .bus_in(bin[W-1:0]),
        .bus_out(lo_out), .bus_oe(lo_oe),
        .ser_lo_out(lo_ser_lo), .ser_hi_out(lo_ser_hi)
    );

    // Second stage chained for the double-width word (R8)
    usr_bus_shreg #(.WIDTH(W)) u_hi_stage (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oc_n(oc_n),
        .ser_up_in(lo_ser_hi), .ser_dn_in(dsl), .bus_in(bin[W2-1:W]),
        .bus_out(hi_out), .bus_oe(hi_oe),
        .ser_lo_out(hi_ser_lo), .ser_hi_out(hi_ser_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_word(input string tag);
        check({tag, " low stage"}, 32'(lo_out), 32'(model[W-1:0]));
        check("R8 high stage", 32'(hi_out), 32'(model[W2-1:W]));
        check("R7 serial outs", {28'd0, hi_ser_hi, hi_ser_lo, lo_ser_hi, lo_ser_lo},
              {28'd0, model[W2-1], model[W], model[W-1], model[0]});
    endtask

    // Drive after a falling edge, step one rising edge, check at the next falling edge
    task automatic cycle(input logic [1:0] s, input logic [1:0] oc, input logic r,
                         input logic l, input logic [W2-1:0] b);
        logic exp_oe;
        string tag;
        sel = s; oc_n = oc; dsr = r; dsl = l; bin = b;
        #0.5;
        exp_oe = (s != 2'b11) && (oc == 2'b00);
        check("R5 bus enable", {30'd0, hi_oe, lo_oe}, {30'd0, exp_oe, exp_oe});
        @(posedge clk);
        case (s)
            2'b00: begin tag = "R1 hold"; end
            2'b01: begin tag = "R2 shift up"; model = {model[W2-2:0], r}; end
            2'b10: begin tag = "R3 shift down"; model = {l, model[W2-1:1]}; end
            default: begin tag = "R4 load"; model = b; end
        endcase
        @(negedge clk);
        check_word(tag);
        if (s == 2'b00) check("R9 readable in hold", 32'(lo_out), 32'(model[W-1:0]));
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clr_n = 1'b0; sel = 2'b11; oc_n = 2'b00; dsr = 1'b0; dsl = 1'b0; bin = '1;
        model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset state low", 32'(lo_out), 32'd0);
        check("R6 reset state high", 32'(hi_out), 32'd0);
        clr_n = 1'b1;

        // Loads of several patterns with drivers requested on and off
        cycle(2'b11, 2'b00, 0, 0, 16'hA5C3);
        cycle(2'b00, 2'b00, 0, 0, 16'h0000);
        cycle(2'b00, 2'b01, 1, 1, 16'hFFFF);
        cycle(2'b11, 2'b10, 0, 0, 16'h1234);
        cycle(2'b00, 2'b11, 0, 0, 16'h0000);
        cycle(2'b11, 2'b01, 0, 0, 16'h8001);

        // Shift up across the stage boundary, then shift down back
        for (int k = 0; k < 20; k++) cycle(2'b01, 2'b00, 1'(k % 3 == 0), 0, 16'hFFFF);
        for (int k = 0; k < 20; k++) cycle(2'b10, 2'(k % 4), 0, 1'(k % 2), 16'h0000);

        // Serial outputs with drivers off
        cycle(2'b11, 2'b11, 0, 0, 16'h8181);
        cycle(2'b00, 2'b11, 0, 0, 16'h0000);

        // Mixed modes
        for (int k = 0; k < 300; k++)
            cycle(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));

        // Clear arriving mid-shift takes effect at once
        cycle(2'b11, 2'b00, 0, 0, 16'hFFFF);
        sel = 2'b01; dsr = 1'b1;
        @(posedge clk);
        model = {model[W2-2:0], 1'b1};
        #1;
        clr_n = 1'b0;
        model = '0;
        #0.5;
        check("R6 immediate clear low", 32'(lo_out), 32'd0);
        check("R6 immediate clear high", 32'(hi_out), 32'd0);
        sel = 2'b11; bin = '1;
        @(posedge clk);
        @(negedge clk);
        check("R6 clear overrides load", {16'd0, hi_out, lo_out}, 32'd0);
        clr_n = 1'b1;
        cycle(2'b01, 2'b00, 1, 0, 16'h0000);
        cycle(2'b00, 2'b00, 0, 0, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule